// File: doc/BRIEF.md
# Parallel Rectangular Region Matcher

The block holds a table of up to `NUM_REGIONS` rectangles. Each rectangle is given by a lowest row, highest row, lowest column and highest column. Every decoded pixel written to the block is tested against all stored rectangles at the same time. The block reports whether the pixel falls inside at least one of them. A downstream reducer uses that bit to keep or drop the pixel.

For each sensor, all rectangles are written first through the region strobe, and then the pixels follow through the pixel strobe. Between sensors a clear input empties the table. Two conditions turn the block into a pass-through, where every pixel is reported as a hit: a bypass input, and a table that overflowed because more rectangles were written than it can hold.

Top module: `roi_matcher`

## Requirements
- R1: After reset, `inRegion`, `pixelValid` and `overflowErr` are 0 and the table is empty.
- R2: A region word carries the lowest row in [31:22], the lowest column in [21:16], the highest row in [15:6] and the highest column in [5:0].
- R3: A pixel word carries the row in [25:16], the column in [15:8] and the ADC value in [7:0]. A pixel hits a region when lowRow <= row <= highRow and lowCol <= column <= highCol, with all bounds inclusive. The 6-bit region columns are compared zero-extended, and the ADC value has no effect.
- R4: The hit result is the OR over all stored regions. Empty slots never hit, so with an empty table and no forcing condition every pixel reports 0.
- R5: `inRegion` and `pixelValid` are registered. Both reflect a pixel one clock after its `pixelWrite` cycle. In any cycle without `pixelWrite`, `pixelValid` returns to 0 on the next clock and `inRegion` holds its value.
- R6: Up to 31 region writes are stored in order with no error. The next region write is not stored and sets `overflowErr`. `overflowErr` stays set until clear or reset, and while it is set every pixel reports 1.
- R7: While `passAll` is 1, every pixel reports 1.
- R8: `clearTable` empties the table, resets the region count and drops `overflowErr` on the next clock. If a region write arrives in the same cycle, the clear wins and the region is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clearTable | input | 1 | Empty the region table, reset the count and drop the error |
| regionWrite | input | 1 | Strobe that stores `regionWord` in the next free slot |
| regionWord | input | 32 | Rectangle bounds |
| pixelWrite | input | 1 | Strobe for a pixel to test |
| pixelWord | input | 26 | Decoded pixel: row, column, ADC value |
| passAll | input | 1 | Bypass: report every pixel as a hit |
| inRegion | output | 1 | Registered hit result |
| pixelValid | output | 1 | High for one cycle when `inRegion` carries a new result |
| overflowErr | output | 1 | Set by a region write to a full table |

## Verification
On every cycle the assertions check the following:
- the region count never exceeds the table size;
- the overflow error is set by a write to a full table, stays set, and is dropped by a clear;
- a forced or bypassed pixel always reports a hit;
- an empty table never reports a hit;
- the one-cycle valid timing, including the held result between pixels.

Only the bench scenarios can show that the bound fields are decoded from the right bit positions and that the comparisons are inclusive at exactly the edges. These scenarios also cover random region sets checked against an independent model, whether a clear racing a region write discards the write, and that the 31st region is still usable while the 32nd is not.

// File: rtl/roi_match_pkg.sv
package roi_match_pkg;
  localparam int ROW_W  = 10;
  localparam int PCOL_W = 8;
  localparam int RCOL_W = 6;
  localparam int ADC_W  = 8;
  localparam int PIX_W  = ROW_W + PCOL_W + ADC_W;
  localparam int REG_W  = 2 * ROW_W + 2 * RCOL_W;

  typedef struct packed {
    logic wrEn;
    logic clearAll;
    logic forceMatch;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [ROW_W-1:0]  rowLo;
    logic [RCOL_W-1:0] colLo;
    logic [ROW_W-1:0]  rowHi;
    logic [RCOL_W-1:0] colHi;
  } regionBounds_t;
endpackage

// File: rtl/roi_match_ctrl.sv
module roi_match_ctrl
  import roi_match_pkg::*;
#(
  parameter int NUM_REGIONS = 31,
  parameter int CNT_W = $clog2(NUM_REGIONS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clearTable,
  input  logic             regionWrite,
  input  logic             passAll,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] slotIdx,
  output logic             overflowErr
);
  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(NUM_REGIONS);

  logic [CNT_W-1:0] regionCount;
  logic             tableFull;

  assign tableFull = (regionCount == FULL_COUNT);

  always_ff @(posedge clk) begin
    if (rst || clearTable) begin
      regionCount <= '0;
      overflowErr <= 1'b0;
    end else if (regionWrite) begin
      if (tableFull) overflowErr <= 1'b1;
      else           regionCount <= regionCount + 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn       = regionWrite && !clearTable && !tableFull;
    strobes.clearAll   = clearTable;
    strobes.forceMatch = passAll || overflowErr;
  end

  assign slotIdx = regionCount;

  // R6: count never passes the table size
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    regionCount <= FULL_COUNT);

  // R6: a write to a full table raises the error
  p_overflow_set_r6: assert property (@(posedge clk) disable iff (rst)
    (regionWrite && tableFull && !clearTable) |=> overflowErr);

  // R6: error is sticky until clear
  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overflowErr && !clearTable) |=> overflowErr);

  // R8: clear empties count and drops error
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clearTable |=> (regionCount == '0 && !overflowErr));
endmodule

// File: rtl/roi_match_dp.sv
module roi_match_dp
  import roi_match_pkg::*;
#(
  parameter int NUM_REGIONS = 31,
  parameter int CNT_W = $clog2(NUM_REGIONS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] slotIdx,
  input  logic [REG_W-1:0] regionWord,
  input  logic             pixelWrite,
  input  logic [PIX_W-1:0] pixelWord,
  output logic             inRegion,
  output logic             pixelValid
);
  regionBounds_t    bounds   [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] slotUsed;
  logic [NUM_REGIONS-1:0] slotHit;
  logic [ROW_W-1:0]  pixRow;
  logic [PCOL_W-1:0] pixCol;
  logic              unusedAdc;
  logic              anyHit;

  assign pixRow    = pixelWord[PIX_W-1 -: ROW_W];
  assign pixCol    = pixelWord[ADC_W +: PCOL_W];
  assign unusedAdc = ^pixelWord[ADC_W-1:0];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    logic [PCOL_W-1:0] colLoExt;
    logic [PCOL_W-1:0] colHiExt;

    always_ff @(posedge clk) begin
      if (rst || strobes.clearAll) begin
        slotUsed[i] <= 1'b0;
      end else if (strobes.wrEn && slotIdx == CNT_W'(i)) begin
        slotUsed[i] <= 1'b1;
        bounds[i]   <= regionBounds_t'(regionWord);
      end
    end

    assign colLoExt = PCOL_W'(bounds[i].colLo);
    assign colHiExt = PCOL_W'(bounds[i].colHi);
    assign slotHit[i] = slotUsed[i]
                     && (pixRow >= bounds[i].rowLo) && (pixRow <= bounds[i].rowHi)
                     && (pixCol >= colLoExt)        && (pixCol <= colHiExt);
  end

  assign anyHit = |slotHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      inRegion   <= 1'b0;
      pixelValid <= 1'b0;
    end else begin
      pixelValid <= pixelWrite;
      if (pixelWrite) inRegion <= strobes.forceMatch || anyHit;
    end
  end

  // R7 R6: forced pixels always hit
  p_force_match_r7: assert property (@(posedge clk) disable iff (rst)
    (pixelWrite && strobes.forceMatch) |=> inRegion);

  // R4: empty table never hits
  p_empty_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (pixelWrite && !strobes.forceMatch && slotUsed == '0) |=> !inRegion);

  // R5: result valid one clock after strobe
  p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
    pixelWrite |=> pixelValid);

  // R5: no strobe keeps result and drops valid
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !pixelWrite |=> (!pixelValid && $stable(inRegion)));
endmodule

// File: rtl/roi_matcher.sv
module roi_matcher
  import roi_match_pkg::*;
#(
  parameter int NUM_REGIONS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clearTable,
  input  logic             regionWrite,
  input  logic [REG_W-1:0] regionWord,
  input  logic             pixelWrite,
  input  logic [PIX_W-1:0] pixelWord,
  input  logic             passAll,
  output logic             inRegion,
  output logic             pixelValid,
  output logic             overflowErr
);
  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] slotIdx;

  roi_match_ctrl #(.NUM_REGIONS(NUM_REGIONS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clearTable(clearTable), .regionWrite(regionWrite),
    .passAll(passAll), .strobes(strobes), .slotIdx(slotIdx),
    .overflowErr(overflowErr)
  );

  roi_match_dp #(.NUM_REGIONS(NUM_REGIONS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .slotIdx(slotIdx),
    .regionWord(regionWord), .pixelWrite(pixelWrite), .pixelWord(pixelWord),
    .inRegion(inRegion), .pixelValid(pixelValid)
  );
endmodule

// File: tb/tb_roi_matcher.sv
`timescale 1ns/1ps
module tb_roi_matcher;
  localparam int N = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clearTable = 1'b0, regionWrite = 1'b0, pixelWrite = 1'b0, passAll = 1'b0;
  logic [31:0] regionWord = '0;
  logic [25:0] pixelWord = '0;
  logic inRegion, pixelValid, overflowErr;

  int checks = 0, failures = 0;
  int mRowLo[N], mRowHi[N], mColLo[N], mColHi[N];
  int mCount = 0;
  bit mOvf = 0;

  always #5 clk = ~clk;

  roi_matcher dut (
    .clk(clk), .rst(rst), .clearTable(clearTable), .regionWrite(regionWrite),
    .regionWord(regionWord), .pixelWrite(pixelWrite), .pixelWord(pixelWord),
    .passAll(passAll), .inRegion(inRegion), .pixelValid(pixelValid),
    .overflowErr(overflowErr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expHit(int row, int col);
    if (passAll || mOvf) return 1'b1;
    for (int i = 0; i < mCount; i++)
      if (row >= mRowLo[i] && row <= mRowHi[i] && col >= mColLo[i] && col <= mColHi[i])
        return 1'b1;
    return 1'b0;
  endfunction

  // R2 layout: rowLo[31:22] colLo[21:16] rowHi[15:6] colHi[5:0]
  task automatic addRegion(int rl, int cl, int rh, int ch);
    @(negedge clk);
    regionWord  = {rl[9:0], cl[5:0], rh[9:0], ch[5:0]};
    regionWrite = 1'b1;
    @(negedge clk);
    regionWrite = 1'b0;
    if (mCount < N) begin
      mRowLo[mCount] = rl; mColLo[mCount] = cl;
      mRowHi[mCount] = rh; mColHi[mCount] = ch;
      mCount++;
    end else mOvf = 1;
  endtask

  task automatic doClear();
    @(negedge clk);
    clearTable = 1'b1;
    @(negedge clk);
    clearTable = 1'b0;
    mCount = 0; mOvf = 0;
  endtask

  // R3 layout: row[25:16] col[15:8] adc[7:0]
  task automatic testPixel(string req, int row, int col, int adc);
    bit e;
    e = expHit(row, col);
    @(negedge clk);
    pixelWord  = {row[9:0], col[7:0], adc[7:0]};
    pixelWrite = 1'b1;
    @(negedge clk);
    pixelWrite = 1'b0;
    check({req, " hit"}, int'(inRegion), int'(e));
    check({req, " valid R5"}, int'(pixelValid), 1);
  endtask

  initial begin : watchdog
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    bit held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 inRegion", int'(inRegion), 0);
    check("R1 pixelValid", int'(pixelValid), 0);
    check("R1 overflowErr", int'(overflowErr), 0);
    testPixel("R1 R4 empty table", 5, 5, 9);

    // Inclusive edges of one region
    addRegion(100, 10, 200, 20);
    testPixel("R3 corner lo", 100, 10, 0);
    testPixel("R3 corner hi", 200, 20, 255);
    testPixel("R3 row below", 99, 15, 0);
    testPixel("R3 row above", 201, 15, 0);
    testPixel("R3 col below", 150, 9, 0);
    testPixel("R3 col above", 150, 21, 0);
    testPixel("R3 wide col", 150, 84, 0);
    testPixel("R3 adc ignored", 150, 15, 170);

    // Hold between pixels
    held = inRegion;
    @(negedge clk);
    check("R5 valid drops", int'(pixelValid), 0);
    check("R5 result held", int'(inRegion), int'(held));

    // R4 OR over two regions
    addRegion(300, 40, 310, 50);
    testPixel("R4 second region", 305, 45, 1);
    testPixel("R4 between regions", 250, 30, 1);

    // R7 bypass
    passAll = 1'b1;
    testPixel("R7 bypass", 0, 255, 3);
    passAll = 1'b0;
    testPixel("R7 bypass off", 0, 255, 3);

    // R8 clear
    doClear();
    testPixel("R8 cleared table", 150, 15, 0);

    // R8 clear wins over write in same cycle
    @(negedge clk);
    regionWord = {10'd0, 6'd0, 10'd1023, 6'd63};
    regionWrite = 1'b1; clearTable = 1'b1;
    @(negedge clk);
    regionWrite = 1'b0; clearTable = 1'b0;
    testPixel("R8 racing write dropped", 500, 30, 0);

    // Random region sets
    for (int set = 0; set < 6; set++) begin
      int k;
      doClear();
      k = 1 + int'($urandom % N);
      for (int r = 0; r < k; r++) begin
        int rl, rh, cl, ch;
        rl = int'($urandom % 1024); rh = rl + int'($urandom % 80); if (rh > 1023) rh = 1023;
        cl = int'($urandom % 64);   ch = cl + int'($urandom % 16); if (ch > 63) ch = 63;
        addRegion(rl, cl, rh, ch);
      end
      for (int p = 0; p < 40; p++) begin
        int row, col, pick;
        pick = int'($urandom % mCount);
        if ($urandom % 2) begin
          row = mRowLo[pick] + int'($urandom % 3) - 1;
          col = mColHi[pick] + int'($urandom % 3) - 1;
        end else begin
          row = int'($urandom % 1024); col = int'($urandom % 70);
        end
        if (row < 0) row = 0; if (row > 1023) row = 1023;
        if (col < 0) col = 0;
        testPixel("R3 R4 random", row, col, int'($urandom % 256));
      end
    end

    // R6 full table then overflow
    doClear();
    for (int r = 0; r < N; r++) addRegion(r * 10, 0, r * 10 + 1, 3);
    check("R6 full no error", int'(overflowErr), 0);
    testPixel("R6 last slot used", 301, 3, 0);
    testPixel("R6 outside all", 305, 3, 0);
    addRegion(900, 0, 901, 1);
    check("R6 overflow raised", int'(overflowErr), 1);
    testPixel("R6 overflow passes", 1000, 200, 0);
    doClear();
    check("R8 error dropped", int'(overflowErr), 0);
    testPixel("R8 after overflow clear", 1000, 200, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule